// File: doc/BRIEF.md
# Converter Reset and Output-Mute Sequencer

This block decides when the digital datapath of a data converter may run and when its output data may be trusted. It merges a supply-good indication and an active-low power-down pin into a single internal reset. When either cause goes away, the block releases that reset only after a fixed number of system clock cycles. It then keeps the output data forced to zero for a fixed number of sample periods, and only after that does it let real samples through.

The supply-good flag acts as an asynchronous reset. It takes effect at once when it drops and is released in step with the system clock. The power-down pin is synchronized and filtered, so a low level seen on a single clock sample is ignored. While power-down is active, the data output driver is disabled (high impedance), the datapath is held in reset and the output stays muted. Leaving power-down restarts the whole two-stage release from the beginning.

The downstream datapath uses the three outputs as follows. The internal reset clears the filter. The mute flag replaces output words with zero. The output enable controls the tri-state data pin.

Top module: `conv_rst_mute_seq`

## Requirements
- R1: While supply_ok_i is low, core_rst_n_o is 0, mute_o is 1 and dout_en_o is 1, and this takes effect without waiting for a clock edge.
- R2: After supply_ok_i rises (with pd_n_i high), core_rst_n_o stays 0 through the first 2 + CLK_HOLD - 1 rising edges of clk_i and is 1 after rising edge number 2 + CLK_HOLD.
- R3: Whenever core_rst_n_o is 0, mute_o is 1.
- R4: Once core_rst_n_o is 1, mute_o stays 1 until the SMP_HOLD-th rising edge at which smp_stb_i is 1, and is 0 after that edge. Strobes seen while core_rst_n_o is 0 are not counted.
- R5: If pd_n_i goes low and stays low, all three outputs keep their earlier values through 3 rising edges. After the 4th rising edge, dout_en_o is 0, core_rst_n_o is 0 and mute_o is 1, and they stay that way while pd_n_i is low. A low level sampled on exactly 2 consecutive rising edges is enough to enter this state.
- R6: A low level on pd_n_i that is sampled on only one rising edge has no effect on any output.
- R7: After pd_n_i returns high, dout_en_o is still 0 after 2 rising edges and is 1 after the 3rd. core_rst_n_o then becomes 1 after a further CLK_HOLD rising edges.
- R8: Power-down discards all progress, whether it is entered during the clock hold, during the mute phase or during normal running. After release, both the full CLK_HOLD clock count and the full SMP_HOLD strobe count are required again, and strobes that arrive during power-down are not counted.
- R9: dout_en_o is 0 only in power-down. In every other phase, including reset and mute, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| supply_ok_i | input | 1 | Supply-good flag; low acts as an asynchronous reset |
| pd_n_i | input | 1 | Power-down request, active low, asynchronous to clk_i |
| smp_stb_i | input | 1 | One-cycle strobe per sample period |
| core_rst_n_o | output | 1 | Internal datapath reset, active low |
| mute_o | output | 1 | High while output data must be forced to zero |
| dout_en_o | output | 1 | Data output driver enable; low means high impedance |

## Verification
The bench builds the block with CLK_HOLD = 6 and SMP_HOLD = 4, keeping the default synchronizer depths. With these values every phase boundary is only a handful of cycles away, so each release can be checked edge by edge at both its last-low and its first-high cycle. The same small sizes make it cheap to sweep the moment power-down arrives across every cycle of the clock hold, the mute phase and normal running. The bench also sweeps the spacing between sample strobes and the width of power-down pulses down to the one-sample glitch that must be ignored.

// File: rtl/rmseq_pkg.sv
package rmseq_pkg;

  typedef enum logic [1:0] {
    SQ_HOLD_CLK  = 2'd0,
    SQ_MUTE_SMP  = 2'd1,
    SQ_RUN       = 2'd2,
    SQ_PDOWN     = 2'd3
  } seq_state_t;

endpackage

// File: rtl/rmseq_rst_sync.sv
// Reset synchronizer: the reset asserts at once and releases on the clock.
module rmseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rmseq_pd_filter.sv
// Synchronizes the power-down pin and requests power-down only after
// MIN_LOW consecutive low samples of the synchronized level.
module rmseq_pd_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pd_n_i,
  output logic pd_req_o
);

  localparam int HIST_W = MIN_LOW - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [HIST_W-1:0]      hist_q, hist_d;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign sync_d = pd_n_i;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pd_n_i};
    end
    if (HIST_W == 1) begin : g_hist1
      assign hist_d = pin_s;
    end else begin : g_histn
      assign hist_d = {hist_q[HIST_W-2:0], pin_s};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  always_comb begin
    pd_req_o = !pin_s && (hist_q == '0);
  end

endmodule

// File: rtl/rmseq_hold_cnt.sv
// Phase counter with written-out clear and increment enables.
module rmseq_hold_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/conv_rst_mute_seq.sv
module conv_rst_mute_seq
  import rmseq_pkg::*;
#(
  parameter int CLK_HOLD    = 1024,
  parameter int SMP_HOLD    = 4480,
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PD_MIN_LOW  = 2
) (
  input  logic clk_i,
  input  logic supply_ok_i,
  input  logic pd_n_i,
  input  logic smp_stb_i,
  output logic core_rst_n_o,
  output logic mute_o,
  output logic dout_en_o
);

  localparam int CNT_TOP = (CLK_HOLD > SMP_HOLD) ? CLK_HOLD : SMP_HOLD;
  localparam int CNT_W   = (CNT_TOP > 2) ? $clog2(CNT_TOP) : 1;
  localparam logic [CNT_W-1:0] CLK_LAST = CNT_W'(CLK_HOLD - 1);
  localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SMP_HOLD - 1);

  logic             rst_n;
  logic             pd_req;
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_inc;

  rmseq_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (supply_ok_i),
    .rst_n_o  (rst_n)
  );

  rmseq_pd_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(PD_MIN_LOW)) i_pd_filter (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .pd_n_i   (pd_n_i),
    .pd_req_o (pd_req)
  );

  rmseq_hold_cnt #(.W(CNT_W)) i_hold_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .cnt_o   (cnt_q)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_HOLD_CLK: if (cnt_q == CLK_LAST) state_d = SQ_MUTE_SMP;
      SQ_MUTE_SMP: if (smp_stb_i && (cnt_q == SMP_LAST)) state_d = SQ_RUN;
      SQ_RUN:      state_d = SQ_RUN;
      SQ_PDOWN:    if (!pd_req) state_d = SQ_HOLD_CLK;
      default:     state_d = SQ_HOLD_CLK;
    endcase
    if (pd_req) state_d = SQ_PDOWN;
  end

  // Counter control: cleared on every phase change and in power-down
  always_comb begin
    cnt_clr = (state_d != state_q) || (state_q == SQ_PDOWN);
    unique case (state_q)
      SQ_HOLD_CLK: cnt_inc = 1'b1;
      SQ_MUTE_SMP: cnt_inc = smp_stb_i;
      default:     cnt_inc = 1'b0;
    endcase
  end

  // State register
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_HOLD_CLK;
    else        state_q <= state_d;
  end

  // Output decode from the state register
  always_comb begin
    core_rst_n_o = (state_q == SQ_MUTE_SMP) || (state_q == SQ_RUN);
    mute_o       = (state_q != SQ_RUN);
    dout_en_o    = (state_q != SQ_PDOWN);
  end

endmodule

// File: rtl/rmseq_chk.sv
module rmseq_chk
  import rmseq_pkg::*;
#(
  parameter int CLK_HOLD = 1024,
  parameter int SMP_HOLD = 4480,
  parameter int CNT_W    = 13
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             smp_stb_i,
  input logic             core_rst_n_o,
  input logic             mute_o,
  input logic             dout_en_o,
  input seq_state_t       state_q,
  input logic [CNT_W-1:0] cnt_q
);

  logic [31:0] clk_run_q;
  logic [31:0] smp_run_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      clk_run_q <= '0;
      smp_run_q <= '0;
    end else begin
      clk_run_q <= (state_q == SQ_HOLD_CLK) ? clk_run_q + 32'd1 : 32'd0;
      if (state_q != SQ_MUTE_SMP) smp_run_q <= 32'd0;
      else if (smp_stb_i)         smp_run_q <= smp_run_q + 32'd1;
    end
  end

  // R2: reset released only after the full clock hold
  p_rst_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(core_rst_n_o) |-> (clk_run_q == 32'(CLK_HOLD)));

  // R3: reset implies mute
  p_mute_in_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !core_rst_n_o |-> mute_o);

  // R4: unmute only after the full strobe count
  p_mute_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(mute_o) |-> (smp_run_q == 32'(SMP_HOLD)));

  // R7: leaving power-down enters the clock hold
  p_pd_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(dout_en_o) |-> (!core_rst_n_o && mute_o));

  // R8: progress counter held at zero in power-down
  p_pd_cnt_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !dout_en_o |-> (cnt_q == '0));

endmodule

bind conv_rst_mute_seq rmseq_chk #(
  .CLK_HOLD (CLK_HOLD),
  .SMP_HOLD (SMP_HOLD),
  .CNT_W    (CNT_W)
) i_rmseq_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .smp_stb_i    (smp_stb_i),
  .core_rst_n_o (core_rst_n_o),
  .mute_o       (mute_o),
  .dout_en_o    (dout_en_o),
  .state_q      (state_q),
  .cnt_q        (cnt_q)
);

// File: tb/test_conv_rst_mute_seq.sv
module test_conv_rst_mute_seq;

  localparam int CLK_HOLD = 6;
  localparam int SMP_HOLD = 4;

  logic clk = 1'b0;
  logic supply_ok, pd_n, smp_stb;
  logic core_rst_n, mute, dout_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  conv_rst_mute_seq #(.CLK_HOLD(CLK_HOLD), .SMP_HOLD(SMP_HOLD)) i_conv_rst_mute_seq (
    .clk_i        (clk),
    .supply_ok_i  (supply_ok),
    .pd_n_i       (pd_n),
    .smp_stb_i    (smp_stb),
    .core_rst_n_o (core_rst_n),
    .mute_o       (mute),
    .dout_en_o    (dout_en)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input string req, input logic r, input logic m, input logic e);
    check(req, "core_rst_n", core_rst_n, r);
    check(req, "mute", mute, m);
    check(req, "dout_en", dout_en, e);
  endtask

  // Clock hold after entering the hold phase; strobes toggle and must be ignored (R4)
  task automatic clk_hold_from_entry();
    for (int i = 0; i < CLK_HOLD; i++) begin
      smp_stb = (i % 2 == 0);
      step(1);
      if (i < CLK_HOLD - 1) outs("R3", 1'b0, 1'b1, 1'b1);
      else                  outs("R2", 1'b1, 1'b1, 1'b1);
    end
    smp_stb = 1'b0;
  endtask

  task automatic run_samples(input int gap);
    for (int k = 1; k <= SMP_HOLD; k++) begin
      smp_stb = 1'b0;
      if (gap > 0) step(gap);
      check("R4", "mute before strobe", mute, 1'b1);
      smp_stb = 1'b1;
      step(1);
      smp_stb = 1'b0;
      check("R4", "mute after strobe", mute, (k < SMP_HOLD) ? 1'b1 : 1'b0);
      check("R4", "core_rst_n", core_rst_n, 1'b1);
    end
  endtask

  task automatic pd_release_and_rerun(input int gap);
    pd_n = 1'b1;
    step(2);
    check("R7", "dout_en after 2 edges", dout_en, 1'b0);
    step(1);
    outs("R7", 1'b0, 1'b1, 1'b1);
    clk_hold_from_entry();
    run_samples(gap);
  endtask

  initial begin
    supply_ok = 1'b0;
    pd_n      = 1'b1;
    smp_stb   = 1'b0;
    step(3);
    outs("R1", 1'b0, 1'b1, 1'b1);

    // Bring-up from supply: 2 sync edges then CLK_HOLD edges
    supply_ok = 1'b1;
    step(1);
    outs("R2", 1'b0, 1'b1, 1'b1);
    step(1);
    outs("R2", 1'b0, 1'b1, 1'b1);
    clk_hold_from_entry();
    run_samples(0);
    step(3);
    outs("R9", 1'b1, 1'b0, 1'b1);

    // R6: single-sample glitch ignored
    pd_n = 1'b0;
    step(1);
    pd_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      outs("R6", 1'b1, 1'b0, 1'b1);
    end

    // R5: minimal two-sample low pulse is recognized, then full restart (R8)
    pd_n = 1'b0;
    step(2);
    pd_n = 1'b1;
    step(1);
    outs("R5", 1'b1, 1'b0, 1'b1);
    step(1);
    outs("R5", 1'b0, 1'b1, 1'b0);
    step(1);
    outs("R7", 1'b0, 1'b1, 1'b1);
    clk_hold_from_entry();
    run_samples(2);

    // Sweep: power-down arriving at every cycle of hold, mute and run phases
    for (int off = 2; off <= CLK_HOLD + 2 * SMP_HOLD + 4; off++) begin
      supply_ok = 1'b0;
      #1;
      outs("R1", 1'b0, 1'b1, 1'b1);
      step(1);
      supply_ok = 1'b1;
      for (int c = 0; c < off; c++) begin
        smp_stb = (c % 2 == 1);
        step(1);
      end
      smp_stb = 1'b0;
      pd_n = 1'b0;
      step(3);
      check("R5", "dout_en before entry", dout_en, 1'b1);
      step(1);
      outs("R5", 1'b0, 1'b1, 1'b0);
      for (int c = 0; c < 5; c++) begin
        smp_stb = (c % 2 == 0);
        step(1);
        outs("R8", 1'b0, 1'b1, 1'b0);
      end
      smp_stb = 1'b0;
      pd_release_and_rerun(off % 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule